// File: doc/BRIEF.md
# Paired-Single Lane Compare Unit

This block executes the four compare forms of a two-lane single-precision vector instruction set. Each operand is a 64-bit word holding two IEEE-754 single-precision values side by side. The instruction word chooses one lane. The unit compares that lane of operand A against the same lane of operand B and produces a one-hot four-bit condition code. It writes the code into one of the eight four-bit fields of a 32-bit condition register and copies the other seven fields from the current register value.

Issue is a single-cycle strobe together with the instruction word, both operands, the current condition register and two mode enables. The updated register, a write strobe and an illegal-instruction flag are all registered and appear one clock later. A compare issued while either mode enable is clear raises the illegal flag and writes nothing. The ordered and unordered forms give the same code, because status-flag side effects belong to a different block.

Top module: `ps_lane_cmp`

## Requirements
- R1: An issued word counts as a compare only if all of these hold: bits [31:26] are 000100, bits [22:21] are 00, bit 0 is 0, and bits [10:1] are one of 0, 32, 64 or 96. Any other word, or any word presented with issue_i low, leaves cr_o unchanged and keeps wr_o and illegal_o low.
- R2: Bit 7 of the word selects the lane. A value of 0 compares lane 0, which is bits [63:32] of both operands. A value of 1 compares lane 1, which is bits [31:0].
- R3: If either compared lane value is a NaN (exponent all ones, mantissa non-zero), the code is 0001.
- R4: For non-NaN values the code is 1000 when A < B, 0100 when A > B and 0010 when A == B.
- R5: Positive and negative zero are equal. Infinities order by their sign. Denormals order by their value.
- R6: The code goes into field n, the field chosen by bits [25:23]. Field n occupies cr_o bits [31-4n:28-4n]. Every other field takes its value from cr_i.
- R7: A compare issued while pair_en_i or quant_en_i is low sets illegal_o for one cycle, keeps wr_o low and leaves cr_o unchanged.
- R8: For a legal compare, wr_o pulses high and cr_o takes its new value on the first rising clock edge after issue.
- R9: While reset is asserted, and right after it, cr_o is zero and wr_o and illegal_o are low.
- R10: The ordered form (bit 6 of the word set) and the unordered form (bit 6 clear) produce the same code for the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction valid strobe |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 64 | Operand A, lane 0 in [63:32], lane 1 in [31:0] |
| opb_i | input | 64 | Operand B, same layout |
| cr_i | input | 32 | Current condition register value |
| pair_en_i | input | 1 | Paired-single arithmetic enable |
| quant_en_i | input | 1 | Quantized load/store enable |
| cr_o | output | 32 | Registered condition register |
| wr_o | output | 1 | Condition register written this cycle |
| illegal_o | output | 1 | Illegal compare flagged this cycle |

## Verification
All three results (the updated cr_o, the wr_o pulse and the illegal_o pulse) are due exactly one rising edge after the issue edge. None of them may show up earlier or later. The bench drives inputs on falling edges. Its behavioural model advances on the same rising edge as the design, and the bench compares all three outputs on the next falling edge, so each result is sampled in the cycle it is due. The directed checks then read the written field from cr_o in that same sampling slot and compare it with a literal code.

// File: rtl/ps_cmp_pkg.sv
package ps_cmp_pkg;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned LANE_W    = 32;
  localparam int unsigned OPND_W    = 2 * LANE_W;
  localparam int unsigned EXP_W     = 8;
  localparam int unsigned MANT_W    = LANE_W - EXP_W - 1;
  localparam int unsigned CR_W      = 32;
  localparam int unsigned FLD_W     = 4;
  localparam int unsigned NFLD      = CR_W / FLD_W;
  localparam int unsigned FSEL_W    = $clog2(NFLD);

  localparam logic [5:0]  PRIM_OP   = 6'b000100;

  typedef enum logic [FLD_W-1:0] {
    CC_LT = 4'b1000,
    CC_GT = 4'b0100,
    CC_EQ = 4'b0010,
    CC_UN = 4'b0001
  } cc_e;

  typedef struct packed {
    logic              hit;
    logic              lane;
    logic              ordered;
    logic [FSEL_W-1:0] crf;
  } dec_t;

  // NaN: exponent saturated and a non-zero fraction
  function automatic logic f_is_nan(input logic [LANE_W-1:0] v);
    return (&v[LANE_W-2 -: EXP_W]) && (|v[MANT_W-1:0]);
  endfunction

  function automatic logic f_is_zero(input logic [LANE_W-1:0] v);
    return ~|v[LANE_W-2:0];
  endfunction

  // Map a sign-magnitude value onto an unsigned total order; both zeros share one key
  function automatic logic [LANE_W-1:0] f_order_key(input logic [LANE_W-1:0] v);
    logic [LANE_W-1:0] k;
    if (f_is_zero(v))      k = {1'b1, {(LANE_W-1){1'b0}}};
    else if (v[LANE_W-1])  k = ~v;
    else                   k = v | {1'b1, {(LANE_W-1){1'b0}}};
    return k;
  endfunction

  function automatic cc_e f_compare(input logic [LANE_W-1:0] a,
                                    input logic [LANE_W-1:0] b);
    logic [LANE_W-1:0] ka;
    logic [LANE_W-1:0] kb;
    cc_e c;
    ka = f_order_key(a);
    kb = f_order_key(b);
    if (f_is_nan(a) || f_is_nan(b)) c = CC_UN;
    else if (ka < kb)               c = CC_LT;
    else if (ka > kb)               c = CC_GT;
    else                            c = CC_EQ;
    return c;
  endfunction

  // Bit mask of field n, field 0 at the top of the register
  function automatic logic [CR_W-1:0] f_field_mask(input logic [FSEL_W-1:0] n);
    logic [CR_W-1:0] m;
    m = {{FLD_W{1'b1}}, {(CR_W-FLD_W){1'b0}}};
    return m >> (FLD_W * n);
  endfunction

  function automatic logic [FLD_W-1:0] f_field_get(input logic [CR_W-1:0] r,
                                                   input logic [FSEL_W-1:0] n);
    logic [CR_W-1:0] s;
    s = r << (FLD_W * n);
    return s[CR_W-1 -: FLD_W];
  endfunction

endpackage

// File: rtl/ps_cmp_decode.sv
module ps_cmp_decode
  import ps_cmp_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o,
  output logic [9:0]        src_regs_o
);

  localparam int unsigned XO_W = 10;

  logic [5:0]      prim;
  logic [1:0]      pad;
  logic [XO_W-1:0] xo;
  logic            rc;
  logic            xo_ok;
  logic            prim_ok;
  logic            pad_ok;

  assign prim = insn_i[31:26];
  assign pad  = insn_i[22:21];
  assign xo   = insn_i[10:1];
  assign rc   = insn_i[0];

  // Extended code: only bit 6 (ordered) and bit 7 (lane) may be non-zero
  assign xo_ok   = (xo[XO_W-1 -: 3] == 3'b000) && (xo[4:0] == 5'b00000);
  assign prim_ok = (prim == PRIM_OP);
  assign pad_ok  = (pad == 2'b00) && !rc;

  assign dec_o.hit     = prim_ok && pad_ok && xo_ok;
  assign dec_o.lane    = xo[6];
  assign dec_o.ordered = xo[5];
  assign dec_o.crf     = insn_i[25:23];

  assign src_regs_o    = insn_i[20:11];

endmodule

// File: rtl/ps_cmp_core.sv
module ps_cmp_core
  import ps_cmp_pkg::*;
(
  input  logic [OPND_W-1:0] opa_i,
  input  logic [OPND_W-1:0] opb_i,
  input  logic              lane_i,
  output logic [LANE_W-1:0] a_lane_o,
  output logic [LANE_W-1:0] b_lane_o,
  output logic              unord_o,
  output cc_e               code_o
);

  logic [LANE_W-1:0] a_sel [2];
  logic [LANE_W-1:0] b_sel [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    // lane 0 sits in the upper half
    assign a_sel[g] = opa_i[OPND_W-1-LANE_W*g -: LANE_W];
    assign b_sel[g] = opb_i[OPND_W-1-LANE_W*g -: LANE_W];
  end

  assign a_lane_o = a_sel[lane_i];
  assign b_lane_o = b_sel[lane_i];
  assign unord_o  = f_is_nan(a_lane_o) || f_is_nan(b_lane_o);
  assign code_o   = f_compare(a_lane_o, b_lane_o);

endmodule

// File: rtl/ps_cmp_crmerge.sv
module ps_cmp_crmerge
  import ps_cmp_pkg::*;
(
  input  logic [CR_W-1:0]   cr_i,
  input  logic [FSEL_W-1:0] crf_i,
  input  logic [FLD_W-1:0]  code_i,
  output logic [CR_W-1:0]   cr_o
);

  for (genvar n = 0; n < NFLD; n++) begin : g_fld
    localparam int unsigned TOP = CR_W - 1 - FLD_W * n;
    assign cr_o[TOP -: FLD_W] = (crf_i == FSEL_W'(n)) ? code_i : cr_i[TOP -: FLD_W];
  end

endmodule

// File: rtl/ps_lane_cmp.sv
module ps_lane_cmp
  import ps_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [31:0]       insn_i,
  input  logic [63:0]       opa_i,
  input  logic [63:0]       opb_i,
  input  logic [31:0]       cr_i,
  input  logic              pair_en_i,
  input  logic              quant_en_i,
  output logic [31:0]       cr_o,
  output logic              wr_o,
  output logic              illegal_o
);

  dec_t              dec_w;
  logic [9:0]        src_regs_w;
  logic [LANE_W-1:0] a_lane_w;
  logic [LANE_W-1:0] b_lane_w;
  logic              unord_w;
  cc_e               code_w;
  logic [CR_W-1:0]   cr_next_w;

  // named events for the checker
  logic              cmp_hit_w;
  logic              mode_ok_w;
  logic              cmp_wr_w;
  logic              cmp_ill_w;

  logic [CR_W-1:0]   cr_q;
  logic              wr_q;
  logic              ill_q;

  ps_cmp_decode u_dec (
    .insn_i     (insn_i),
    .dec_o      (dec_w),
    .src_regs_o (src_regs_w)
  );

  ps_cmp_core u_core (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .lane_i   (dec_w.lane),
    .a_lane_o (a_lane_w),
    .b_lane_o (b_lane_w),
    .unord_o  (unord_w),
    .code_o   (code_w)
  );

  ps_cmp_crmerge u_merge (
    .cr_i   (cr_i),
    .crf_i  (dec_w.crf),
    .code_i (code_w),
    .cr_o   (cr_next_w)
  );

  assign cmp_hit_w = issue_i && dec_w.hit;
  assign mode_ok_w = pair_en_i && quant_en_i;
  assign cmp_wr_w  = cmp_hit_w && mode_ok_w;
  assign cmp_ill_w = cmp_hit_w && !mode_ok_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q  <= '0;
      wr_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      wr_q  <= cmp_wr_w;
      ill_q <= cmp_ill_w;
      if (cmp_wr_w) cr_q <= cr_next_w;
    end
  end

  assign cr_o      = cr_q;
  assign wr_o      = wr_q;
  assign illegal_o = ill_q;

endmodule

// File: rtl/ps_lane_cmp_chk.sv
module ps_lane_cmp_chk
  import ps_cmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_hit_w,
  input logic              mode_ok_w,
  input logic              unord_w,
  input dec_t              dec_w,
  input logic [9:0]        src_regs_w,
  input logic [CR_W-1:0]   cr_i,
  input logic [CR_W-1:0]   cr_o,
  input logic              wr_o,
  input logic              illegal_o
);

  logic [FSEL_W-1:0] crf_q;
  logic [CR_W-1:0]   crin_q;
  logic              unord_q;
  logic [9:0]        regs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crf_q   <= '0;
      crin_q  <= '0;
      unord_q <= 1'b0;
      regs_q  <= '0;
    end else begin
      crf_q   <= dec_w.crf;
      crin_q  <= cr_i;
      unord_q <= unord_w;
      regs_q  <= src_regs_w;
    end
  end

  // R7
  wr_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && illegal_o));

  // R7
  ill_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit_w && !mode_ok_w) |=> illegal_o);

  // R7
  ill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(cr_o));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_o |-> $stable(cr_o));

  // R8
  wr_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit_w && mode_ok_w) |=> wr_o);

  // R8
  wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(cmp_hit_w && mode_ok_w));

  // R4
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> ($countones(f_field_get(cr_o, crf_q)) == 1));

  // R3
  nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && unord_q) |-> (f_field_get(cr_o, crf_q) == 4'b0001));

  // R6
  other_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (((cr_o ^ crin_q) & ~f_field_mask(crf_q)) == '0));

  // R1
  src_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> !$isunknown(regs_q));

endmodule

bind ps_lane_cmp ps_lane_cmp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_hit_w  (cmp_hit_w),
  .mode_ok_w  (mode_ok_w),
  .unord_w    (unord_w),
  .dec_w      (dec_w),
  .src_regs_w (src_regs_w),
  .cr_i       (cr_i),
  .cr_o       (cr_o),
  .wr_o       (wr_o),
  .illegal_o  (illegal_o)
);

// File: tb/ps_lane_cmp_bench.sv
`timescale 1ns/1ps
module ps_lane_cmp_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [31:0] cr_i = '0;
  logic        pair_en_i = 1'b1;
  logic        quant_en_i = 1'b1;
  logic [31:0] cr_o;
  logic        wr_o;
  logic        illegal_o;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  logic [31:0] m_cr = '0;
  logic        m_wr = 1'b0;
  logic        m_ill = 1'b0;

  always #10 clk = ~clk;

  ps_lane_cmp u_ps_lane_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .insn_i     (insn_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .cr_i       (cr_i),
    .pair_en_i  (pair_en_i),
    .quant_en_i (quant_en_i),
    .cr_o       (cr_o),
    .wr_o       (wr_o),
    .illegal_o  (illegal_o)
  );

  // Reference compare, written as sign/magnitude case analysis
  function automatic logic [3:0] ref_cmp(input logic [31:0] a, input logic [31:0] b);
    bit na, nb, za, zb, sa, sb;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    if (na || nb) return 4'b0001;
    za = (a[30:0] == 0);
    zb = (b[30:0] == 0);
    if (za && zb) return 4'b0010;
    sa = za ? 1'b0 : a[31];
    sb = zb ? 1'b0 : b[31];
    if (sa != sb) return sa ? 4'b1000 : 4'b0100;
    if (a[30:0] == b[30:0]) return 4'b0010;
    if ((a[30:0] < b[30:0]) ^ sa) return 4'b1000;
    return 4'b0100;
  endfunction

  function automatic logic [31:0] mk(input int crf, input bit lane, input bit ord);
    return {6'b000100, 3'(crf), 2'b00, 5'd3, 5'd4, 3'b000, lane, ord, 5'b00000, 1'b0};
  endfunction

  // Behavioural model, advanced on the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cr = 0; m_wr = 0; m_ill = 0;
    end else begin
      int ext;
      bit hit;
      ext = int'(insn_i[10:1]);
      hit = issue_i && insn_i[31:26] == 6'd4 && insn_i[22:21] == 0 && !insn_i[0]
            && (ext == 0 || ext == 32 || ext == 64 || ext == 96);
      m_wr = 0; m_ill = 0;
      if (hit && !(pair_en_i && quant_en_i)) m_ill = 1;
      else if (hit) begin
        logic [31:0] a, b;
        logic [3:0] c;
        int f;
        a = (ext >= 64) ? opa_i[31:0] : opa_i[63:32];
        b = (ext >= 64) ? opb_i[31:0] : opb_i[63:32];
        c = ref_cmp(a, b);
        f = int'(insn_i[25:23]);
        m_cr = cr_i;
        for (int k = 0; k < 4; k++) m_cr[31 - 4*f - k] = c[3-k];
        m_wr = 1;
      end
    end
  end

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (cr_o !== m_cr || wr_o !== m_wr || illegal_o !== m_ill) begin
        errors++;
        $display("FAIL %s: cr=%h wr=%b ill=%b expected cr=%h wr=%b ill=%b",
                 cur_req, cr_o, wr_o, illegal_o, m_cr, m_wr, m_ill);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_field(input string req, input int crf, input logic [3:0] exp_c);
    logic [3:0] got;
    got = cr_o[31 - 4*crf -: 4];
    checks++;
    if (got !== exp_c) begin
      errors++;
      $display("FAIL %s: field%0d=%b expected %b", req, crf, got, exp_c);
    end
  endtask

  // Issue one compare; results due at the next rising edge, sampled on the falling one
  task automatic cmp1(input string req, input int crf, input bit lane, input bit ord,
                      input logic [31:0] a, input logic [31:0] b, input logic [3:0] exp_c);
    cur_req = req;
    insn_i  = mk(crf, lane, ord);
    opa_i   = lane ? {32'h7FC0_0000, a} : {a, 32'h7FC0_0000};
    opb_i   = lane ? {32'h0000_0000, b} : {b, 32'h0000_0000};
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    expect_field(req, crf, exp_c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (cr_o !== 0 || wr_o !== 0 || illegal_o !== 0) begin
      errors++;
      $display("FAIL R9: cr=%h wr=%b ill=%b expected 0 0 0", cr_o, wr_o, illegal_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cr_i = 32'h1234_5678;

    // R4 basic orderings
    cmp1("R4", 0, 0, 0, 32'h3F80_0000, 32'h4000_0000, 4'b1000);
    cmp1("R4", 1, 0, 0, 32'h4000_0000, 32'h3F80_0000, 4'b0100);
    cmp1("R4", 2, 1, 0, 32'h4040_0000, 32'h4040_0000, 4'b0010);
    cmp1("R4", 3, 1, 1, 32'hBF80_0000, 32'hC000_0000, 4'b0100);
    cmp1("R4", 4, 0, 1, 32'hC000_0000, 32'h3F80_0000, 4'b1000);
    // R3 NaN either side
    cmp1("R3", 5, 0, 0, 32'h7FC0_0000, 32'h3F80_0000, 4'b0001);
    cmp1("R3", 6, 1, 1, 32'h3F80_0000, 32'hFF80_0001, 4'b0001);
    cmp1("R3", 7, 0, 1, 32'h7F80_0000, 32'h7F80_0000, 4'b0010);
    // R5 zeros, infinities, denormals
    cmp1("R5", 0, 0, 0, 32'h8000_0000, 32'h0000_0000, 4'b0010);
    cmp1("R5", 1, 1, 0, 32'h7F80_0000, 32'h7F7F_FFFF, 4'b0100);
    cmp1("R5", 2, 0, 1, 32'hFF80_0000, 32'h8000_0001, 4'b1000);
    cmp1("R5", 3, 1, 0, 32'h0000_0001, 32'h8000_0000, 4'b0100);
    cmp1("R5", 4, 0, 0, 32'h8000_0002, 32'h8000_0001, 4'b1000);
    // R10 ordered and unordered forms agree
    cmp1("R10", 5, 1, 0, 32'h4120_0000, 32'h4110_0000, 4'b0100);
    cmp1("R10", 5, 1, 1, 32'h4120_0000, 32'h4110_0000, 4'b0100);

    // R2 lane choice: lanes hold opposite orderings
    cur_req = "R2";
    insn_i = mk(2, 1'b0, 1'b0);
    opa_i = {32'h3F80_0000, 32'h4000_0000};
    opb_i = {32'h4000_0000, 32'h3F80_0000};
    issue_i = 1'b1; @(negedge clk); issue_i = 1'b0;
    expect_field("R2", 2, 4'b1000);
    insn_i = mk(2, 1'b1, 1'b0);
    issue_i = 1'b1; @(negedge clk); issue_i = 1'b0;
    expect_field("R2", 2, 4'b0100);

    // R6 untouched fields follow cr_i
    cur_req = "R6";
    cr_i = 32'hA5C3_F00F;
    insn_i = mk(6, 1'b0, 1'b0);
    opa_i = '0; opb_i = '0;
    issue_i = 1'b1; @(negedge clk); issue_i = 1'b0;
    checks++;
    if (cr_o !== 32'hA5C3_F02F) begin
      errors++;
      $display("FAIL R6: cr=%h expected a5c3f02f", cr_o);
    end

    // R7 enables
    cur_req = "R7";
    for (int e = 0; e < 3; e++) begin
      pair_en_i = e[0]; quant_en_i = e[1];
      cr_i = 32'hFFFF_FFFF;
      insn_i = mk(0, 1'b0, 1'b0);
      issue_i = 1'b1; @(negedge clk); issue_i = 1'b0;
      checks++;
      if (illegal_o !== 1'b1 || wr_o !== 1'b0 || cr_o !== 32'hA5C3_F02F) begin
        errors++;
        $display("FAIL R7: ill=%b wr=%b cr=%h expected 1 0 a5c3f02f", illegal_o, wr_o, cr_o);
      end
    end
    pair_en_i = 1'b1; quant_en_i = 1'b1;

    // R1 non-matching words and no issue
    cur_req = "R1";
    cr_i = 32'h0;
    for (int t = 0; t < 5; t++) begin
      logic [31:0] w;
      w = mk(1, 1'b0, 1'b0);
      case (t)
        0: w[31:26] = 6'b000101;
        1: w[21] = 1'b1;
        2: w[0] = 1'b1;
        3: w[10:1] = 10'd528;
        default: w = w;
      endcase
      insn_i = w;
      issue_i = (t != 4);
      @(negedge clk); issue_i = 1'b0;
      checks++;
      if (wr_o !== 1'b0 || illegal_o !== 1'b0 || cr_o !== 32'hA5C3_F02F) begin
        errors++;
        $display("FAIL R1: wr=%b ill=%b cr=%h expected 0 0 a5c3f02f", wr_o, illegal_o, cr_o);
      end
    end

    // R8 back-to-back issue, random operands, model compared each cycle
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      insn_i = mk(int'(r[2:0]), r[3], r[4]);
      if (r[7:5] == 0) insn_i[0] = 1'b1;
      opa_i = {$urandom, $urandom};
      opb_i = (r[9:8] == 0) ? opa_i : {$urandom, $urandom};
      if (r[11:10] == 0) opb_i[62:55] = 8'hFF;
      cr_i = $urandom;
      pair_en_i = (r[15:12] != 0);
      quant_en_i = 1'b1;
      issue_i = r[16] | r[17];
      @(negedge clk);
    end
    issue_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule